// File: doc/BRIEF.md
# Octal Double-Buffered DAC Register Interface

This block is the digital front end of an eight-channel, 14-bit voltage-output converter. A host writes 14-bit codes over a parallel bus into one of eight input registers. It picks the register with a 3-bit address and frames each write with active-low select and write strobes. A separate active-low load strobe moves the contents of every input register into the matching DAC register at the same moment, so all channels can change together. If the load strobe is held low, each channel instead updates as soon as it is written. The eight DAC register codes leave the block as one flat vector, and the analog stage that follows turns them into voltages.

The block has an active-low clear. While clear is low, a ground-select flag is raised at once, without waiting for the clock. The flag tells the analog stage to drive every output to its ground-sense level. Neither register bank is touched, so when clear is released the outputs return to the stored codes. The block runs on an internal clock: the bus lines pass through a two-stage synchroniser, and the write's rising edge is detected on the synchronised strobe.

Top module: `octal_dac_regs`

## Requirements
- R1: While reset is low at a clock edge, all eight output codes are zero and the ground-select flag is 1. The flag falls at the first clock edge that sees reset high.
- R2: A write happens only when the write strobe rises after a sample in which both write and select were low. The data present while the strobe was low goes into the addressed input register. The register changes at the second clock edge after the edge that first samples the write strobe high. With load high, no output code changes.
- R3: A write strobe pulse with select held high stores nothing. A later load shows the previous contents of the targeted channel.
- R4: While the synchronised load is low, every DAC register takes the value of its input register at each clock edge. Load is seen at the second clock edge after it is first sampled low.
- R5: If load is low in the same cycle as a detected write, the written channel's DAC register takes the newly written data. With load tied low, a write shows on the output at the same edge as the input register update.
- R6: Address value k (0 to 7) selects channel k. The code of channel k is output on bits k*14+13 down to k*14 of the code vector.
- R7: While clear is low, the ground-select flag is 1 without any clock edge. The output codes stay unchanged, and writes and loads still update the registers.
- R8: At the first clock edge after clear returns high, the ground-select flag falls to 0, and the outputs again carry the stored DAC codes.
- R9: Codes are straight binary, 14 bits wide, with bit 13 the MSB. The values 0x0000, 0x2000 and 0x3FFF pass unaltered from bus to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe, captured on its rising edge |
| bus_addr | input | 3 | Channel address, 0 selects channel A, 7 selects channel H |
| bus_data | input | 14 | Parallel data word, bit 13 is the MSB |
| load_n | input | 1 | Active-low load of all DAC registers |
| clr_n | input | 1 | Asynchronous active-low clear of the output selection |
| ch_code | output | 112 | Eight 14-bit DAC register codes, channel k at bits k*14 +: 14 |
| out_gnd_sel | output | 1 | 1 selects ground-sense level for all channel outputs |

## Verification
Several checks run on every cycle:
- at most one input register is written per cycle;
- input registers hold when no write is detected;
- both banks agree after any cycle with load active;
- the flag is raised whenever clear is sampled low;
- the flag drops one edge after clear is seen high.

Other behaviour only the bench scenarios can show:
- the exact two-edge synchroniser latency;
- the address-to-channel mapping;
- that a write with select high is dropped;
- that the code output keeps its value across a clear;
- that the flag responds to clear between clock edges.

The bench covers these by comparing the outputs against a behavioural model on every cycle, and by adding targeted checks.

// File: rtl/octal_dac_pkg.sv
// Package: shared defaults and types for the octal DAC register interface.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package octal_dac_pkg;

    localparam int unsigned DEF_CODE_W  = 14;
    localparam int unsigned DEF_NUM_CH  = 8;
    localparam int unsigned DEF_SYNC_ST = 2;

    // Strobe group carried through the synchroniser as one vector.
    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic load_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, load_n: 1'b1};

    // Address width for a channel count, at least one bit.
    function automatic int unsigned addr_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/odac_sync.sv
// Module: odac_sync
// A multi-stage synchroniser chain for a vector of asynchronous inputs.
// Assumes the bits of a data vector are held stable by the sender while the
// strobe that qualifies them is active. Synchronous active-low reset.
module odac_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: sample the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            // Later flops: shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/odac_input_bank.sv
// Module: odac_input_bank
// Decodes the channel address of a detected write and holds the eight input
// registers. Assumes wr_evt is a single-cycle pulse. Addresses beyond NUM_CH-1
// select nothing.
module odac_input_bank #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 14,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_evt,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CODE_W-1:0]          wr_data,
    output logic [NUM_CH-1:0]          wr_sel,
    output logic [NUM_CH*CODE_W-1:0]   in_flat
);

    logic [CODE_W-1:0] in_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Decode: this channel is targeted by the current write.
        assign wr_sel[c] = wr_evt && (wr_addr == ADDR_W'(c));

        // Input register: capture bus data on a decoded write.
        always_ff @(posedge clk) begin
            if (!rst_n)         in_q[c] <= '0;
            else if (wr_sel[c]) in_q[c] <= wr_data;
        end

        assign in_flat[c*CODE_W +: CODE_W] = in_q[c];
    end

endmodule

// File: rtl/odac_dac_bank.sv
// Module: odac_dac_bank
// Second register level. While load is active every DAC register copies its
// input register. A write in the same cycle forwards the new data directly.
module odac_dac_bank #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_act,
    input  logic [NUM_CH-1:0]        wr_sel,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic [NUM_CH*CODE_W-1:0] in_flat,
    output logic [NUM_CH*CODE_W-1:0] dac_flat
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CODE_W-1:0] dac_q;

        // DAC register: forward fresh write data, else copy the input register.
        always_ff @(posedge clk) begin
            if (!rst_n)                      dac_q <= '0;
            else if (load_act && wr_sel[c])  dac_q <= wr_data;
            else if (load_act)               dac_q <= in_flat[c*CODE_W +: CODE_W];
        end

        assign dac_flat[c*CODE_W +: CODE_W] = dac_q;
    end

endmodule

// File: rtl/odac_clear_flag.sv
// Module: odac_clear_flag
// Ground-select flag. It is set asynchronously by the clear input, held set
// through reset, and released by the clock once clear and reset are inactive.
module odac_clear_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic gnd_sel
);

    // Flag register: asynchronous set from clear, synchronous set from reset.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      gnd_sel <= 1'b1;
        else if (!rst_n) gnd_sel <= 1'b1;
        else             gnd_sel <= 1'b0;
    end

endmodule

// File: rtl/octal_dac_regs.sv
// Module: octal_dac_regs (top)
// Double-buffered register interface for an eight-channel 14-bit converter.
// The bus strobes, address and data pass through a synchroniser. A write is
// detected on the rising edge of the synchronised write strobe while select
// was low. Load copies all input registers to the DAC registers. Clear raises
// the ground-select flag asynchronously and touches no register.
module octal_dac_regs
    import octal_dac_pkg::*;
#(
    parameter int unsigned NUM_CH      = DEF_NUM_CH,
    parameter int unsigned CODE_W      = DEF_CODE_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_ST,
    localparam int unsigned ADDR_W     = addr_width(NUM_CH),
    localparam int unsigned BUS_W      = ADDR_W + CODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_cs_n,
    input  logic                     bus_wr_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [CODE_W-1:0]        bus_data,
    input  logic                     load_n,
    input  logic                     clr_n,
    output logic [NUM_CH*CODE_W-1:0] ch_code,
    output logic                     out_gnd_sel
);

    strobe_t              strb_raw, strb_sync, strb_prev;
    logic [BUS_W-1:0]     bus_sync, bus_prev;
    logic                 wr_evt;
    logic                 load_sync;
    logic [NUM_CH-1:0]    wr_sel;
    logic [NUM_CH*CODE_W-1:0] in_flat;

    assign strb_raw = '{cs_n: bus_cs_n, wr_n: bus_wr_n, load_n: load_n};

    odac_sync #(.W($bits(strobe_t)), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_sync)
    );

    odac_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({bus_addr, bus_data}), .q(bus_sync)
    );

    // Edge-detect history: previous synchronised strobes and bus values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_prev <= STROBE_IDLE;
            bus_prev  <= '0;
        end else begin
            strb_prev <= strb_sync;
            bus_prev  <= bus_sync;
        end
    end

    assign wr_evt    = strb_sync.wr_n && !strb_prev.wr_n && !strb_prev.cs_n;
    assign load_sync = !strb_sync.load_n;

    odac_input_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_in_bank (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt),
        .wr_addr(bus_prev[BUS_W-1 -: ADDR_W]), .wr_data(bus_prev[CODE_W-1:0]),
        .wr_sel(wr_sel), .in_flat(in_flat)
    );

    odac_dac_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dac_bank (
        .clk(clk), .rst_n(rst_n), .load_act(load_sync), .wr_sel(wr_sel),
        .wr_data(bus_prev[CODE_W-1:0]), .in_flat(in_flat), .dac_flat(ch_code)
    );

    odac_clear_flag u_clr_flag (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .gnd_sel(out_gnd_sel)
    );

endmodule

// File: rtl/octal_dac_regs_checker.sv
// Module: octal_dac_regs_checker
// Concurrent checks on the register interface, bound into the top module.
module octal_dac_regs_checker #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clr_n,
    input logic                     out_gnd_sel,
    input logic                     load_sync,
    input logic [NUM_CH-1:0]        wr_sel,
    input logic [NUM_CH*CODE_W-1:0] in_flat,
    input logic [NUM_CH*CODE_W-1:0] ch_code
);

    // R2: a detected write targets at most one input register.
    p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R3: input registers hold when no write is decoded.
    p_input_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == '0) |=> $stable(in_flat));

    // R4: after a cycle with load active, both banks agree.
    p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_sync |=> (ch_code == in_flat));

    // R4: without load, the DAC codes do not move.
    p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_sync |=> $stable(ch_code));

    // R7: clear low always shows the ground-select flag.
    p_clear_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> out_gnd_sel);

    // R8: with clear high at an edge, the flag is low afterwards unless clear fell again.
    p_clear_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n |=> (!out_gnd_sel || !clr_n));

endmodule

bind octal_dac_regs octal_dac_regs_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .out_gnd_sel(out_gnd_sel),
    .load_sync(load_sync), .wr_sel(wr_sel), .in_flat(in_flat), .ch_code(ch_code)
);

// File: tb/octal_dac_regs_bench.sv
// Bench for octal_dac_regs: a behavioural cycle model compared every clock,
// plus scenario checks tagged by requirement.
module octal_dac_regs_bench;

    localparam int CLK_T  = 10;
    localparam int NCH    = 8;
    localparam int CW     = 14;
    localparam int HIST   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [13:0] data = '0;
    logic [NCH*CW-1:0] code;
    logic gnd_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // Behavioural model state.
    int m_in  [NCH];
    int m_dac [NCH];
    int m_flag_reg = 1;
    int h_wr [$], h_cs [$], h_ld [$], h_addr [$], h_data [$];

    octal_dac_regs u_octal_dac_regs (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n),
        .bus_addr(addr), .bus_data(data), .load_n(ld_n), .clr_n(clr_n),
        .ch_code(code), .out_gnd_sel(gnd_sel)
    );

    always #(CLK_T/2) clk = ~clk;

    function automatic int chan(input int k);
        return int'(code[k*CW +: CW]);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic hist_idle();
        h_wr = {1, 1, 1}; h_cs = {1, 1, 1}; h_ld = {1, 1, 1};
        h_addr = {0, 0, 0}; h_data = {0, 0, 0};
    endtask

    // Model update at each edge, then compare after the outputs settle.
    initial begin
        hist_idle();
        foreach (m_in[i]) begin m_in[i] = 0; m_dac[i] = 0; end
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                foreach (m_in[i]) begin m_in[i] = 0; m_dac[i] = 0; end
                m_flag_reg = 1;
                hist_idle();
            end else begin
                // h[0]=sample one edge ago, h[1]=synchronised, h[2]=previous.
                if (h_wr[1] == 1 && h_wr[2] == 0 && h_cs[2] == 0)
                    m_in[h_addr[2]] = h_data[2];
                if (h_ld[1] == 0)
                    for (int c = 0; c < NCH; c++) m_dac[c] = m_in[c];
                m_flag_reg = clr_n ? 0 : 1;
                void'(h_wr.pop_back());   h_wr.push_front(int'(wr_n));
                void'(h_cs.pop_back());   h_cs.push_front(int'(cs_n));
                void'(h_ld.pop_back());   h_ld.push_front(int'(ld_n));
                void'(h_addr.pop_back()); h_addr.push_front(int'(addr));
                void'(h_data.pop_back()); h_data.push_front(int'(data));
            end
            #(CLK_T/4);
            if (!done) begin
                int bad = -1;
                for (int c = 0; c < NCH; c++)
                    if (bad < 0 && chan(c) != m_dac[c]) bad = c;
                if (bad >= 0) check("cycle-model code", chan(bad), m_dac[bad]);
                else          check("cycle-model code", 0, 0);
                check("cycle-model flag", int'(gnd_sel), (m_flag_reg != 0 || !clr_n) ? 1 : 0);
            end
        end
    end

    task automatic bus_write(input int a, input int d, input bit sel);
        @(negedge clk);
        addr = 3'(a); data = 14'(d); cs_n = !sel; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic pulse_load();
        @(negedge clk); ld_n = 1'b0;
        @(negedge clk); ld_n = 1'b1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int t0;
        // R1: reset state.
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCH; c++) check("R1 reset code", chan(c), 0);
        check("R1 flag in reset", int'(gnd_sel), 1);
        rst_n = 1'b1;
        #1 check("R1 flag before first edge", int'(gnd_sel), 1);
        @(posedge clk); #(CLK_T/4);
        check("R1 flag after first edge", int'(gnd_sel), 0);

        // R2: write with load high does not reach the output; exact latency.
        bus_write(3, 14'h1234, 1);
        settle();
        check("R2 no output change without load", chan(3), 0);
        pulse_load(); settle();
        check("R2 written code after load", chan(3), 14'h1234);

        // R3: write with select high is ignored.
        bus_write(3, 14'h0AAA, 0);
        pulse_load(); settle();
        check("R3 ignored write", chan(3), 14'h1234);

        // R6: every address maps to its own channel.
        for (int k = 0; k < NCH; k++) bus_write(k, 14'h0811 * k + 5, 1);
        settle();
        check("R4 held before load", chan(5), 0);
        pulse_load(); settle();
        for (int k = 0; k < NCH; k++) check("R6 channel map", chan(k), 14'h0811 * k + 5);

        // R9: boundary codes pass unaltered.
        bus_write(0, 14'h3FFF, 1);
        bus_write(1, 14'h2000, 1);
        bus_write(2, 14'h0000, 1);
        pulse_load(); settle();
        check("R9 full scale", chan(0), 14'h3FFF);
        check("R9 mid scale", chan(1), 14'h2000);
        check("R9 zero", chan(2), 0);

        // R5: load tied low, output follows the write edge.
        @(negedge clk); ld_n = 1'b0;
        @(negedge clk); addr = 3'd6; data = 14'h1F0F; cs_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;            // sampled high at next edge E0
        @(posedge clk); t0 = 0; // E0
        @(posedge clk); #(CLK_T/4);
        check("R5 not yet at E1", chan(6), 14'h0811 * 6 + 5);
        @(posedge clk); #(CLK_T/4);
        check("R5 updated at E2", chan(6), 14'h1F0F);
        @(negedge clk); cs_n = 1'b1; ld_n = 1'b1;
        settle();

        // R7: clear raises the flag between edges and keeps codes.
        @(negedge clk); clr_n = 1'b0;
        #1 check("R7 async flag", int'(gnd_sel), 1);
        check("R7 code kept", chan(6), 14'h1F0F);
        bus_write(7, 14'h0123, 1);
        pulse_load(); settle();
        check("R7 write during clear", chan(7), 14'h0123);
        check("R7 flag held", int'(gnd_sel), 1);

        // R8: release clear.
        @(negedge clk); clr_n = 1'b1;
        #1 check("R8 flag until edge", int'(gnd_sel), 1);
        @(posedge clk); #(CLK_T/4);
        check("R8 flag released", int'(gnd_sel), 0);
        check("R8 codes restored", chan(0), 14'h3FFF);

        settle();
        finish_run();
    end

endmodule